// File: doc/BRIEF.md
# Bit-Sliced Arithmetic and Logic Unit with Signed Compare

A purely combinational arithmetic/logic unit of parameterised width, 16 bits by default. It is a ripple of identical one-bit slices. Each slice can invert either operand on its way in. It has a full adder whose carry feeds the next slice up. A two-bit operation code picks the slice result: logical AND, logical OR, adder sum, or a `less` input passed straight through.

A signed compare reuses the subtract path. The top slice's raw adder sum is its sign bit. That bit is routed back into the bottom slice's `less` input, and the `less` inputs of all other slices are tied to zero. The compare result is therefore 1 or 0 in bit 0, with every upper bit cleared. Subtraction and compare both come from inverting operand b and setting the shared carry-in. A flag stage reports signed overflow from the carries around the top slice, and reports whether the result is all zeros.

Top module: `alu_bitslice`

## Requirements
- R1: With `op_sel` = 2'b00, `result` is the bitwise AND of A' and B'. A' is `opnd_a` inverted when `inv_a` = 1 and unchanged otherwise. B' is `opnd_b` treated the same way under `inv_b`.
- R2: With `op_sel` = 2'b01, `result` is the bitwise OR of A' and B'.
- R3: With `op_sel` = 2'b10, `result` is (A' + B' + `carry_in`) modulo 2^16.
- R4: With `inv_a` = 0, `inv_b` = 1, `carry_in` = 1 and `op_sel` = 2'b10, `result` equals `opnd_a` − `opnd_b` modulo 2^16. For example, 0x8000 − 1 gives 0x7FFF.
- R5: With `op_sel` = 2'b11, `result[0]` is bit 15 of (A' + B' + `carry_in`) and `result[15:1]` is 0. With the subtract settings of R4, this reads 1 when a < b as signed numbers, ignoring any overflow. Equal operands give 0.
- R6: With `op_sel` = 2'b10, `overflow` is 1 exactly when the sum of R3 overflows as a signed number: A' and B' share a sign bit and the bit 15 of the sum differs from it. For example, 0x7FFF + 1 sets `overflow`, and 0x8000 − 1 also sets it.
- R7: For every `op_sel`, `zero` is 1 exactly when `result` is 0x0000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_a | input | 16 | Operand a |
| opnd_b | input | 16 | Operand b |
| inv_a | input | 1 | Invert operand a in every slice |
| inv_b | input | 1 | Invert operand b in every slice |
| carry_in | input | 1 | Carry into bit 0 |
| op_sel | input | 2 | 00 AND, 01 OR, 10 sum, 11 signed compare |
| result | output | 16 | Slice outputs |
| overflow | output | 1 | Signed overflow of the adder path |
| zero | output | 1 | Result is all zeros |

## Verification
Overflow and the zero flag can both be raised by one sum. For example, 0x8000 + 0x8000 wraps to 0x0000 with signed overflow, so the bench drives that case directly and judges both flags on the same vector. It also drives a compare that follows an overflowing subtraction (0x8000 against 1). There, bit 0 must follow the raw sign bit, which is 0, even though the true signed answer differs. A mass of random vectors, with random inversion and carry-in under every operation code, is judged against a bench model of A', B' and the 17-bit sum.

// File: rtl/alu_pkg.sv
package alu_pkg;
  typedef enum logic [1:0] {
    ALU_AND  = 2'b00,
    ALU_OR   = 2'b01,
    ALU_SUM  = 2'b10,
    ALU_LESS = 2'b11
  } alu_op_e;
endpackage

// File: rtl/alu_slice.sv
module alu_slice
  import alu_pkg::*;
(
  input  logic    a,
  input  logic    b,
  input  logic    inv_a,
  input  logic    inv_b,
  input  logic    cin,
  input  logic    less,
  input  alu_op_e op,
  output logic    y,
  output logic    cout,
  output logic    sum_raw
);
  logic a_eff, b_eff;

  always_comb begin
    a_eff   = a ^ inv_a;
    b_eff   = b ^ inv_b;
    sum_raw = a_eff ^ b_eff ^ cin;
    cout    = (a_eff & b_eff) | (cin & (a_eff ^ b_eff));
    unique case (op)
      ALU_AND: y = a_eff & b_eff;
      ALU_OR:  y = a_eff | b_eff;
      ALU_SUM: y = sum_raw;
      default: y = less;
    endcase
  end
endmodule

// File: rtl/alu_flags.sv
module alu_flags #(
  parameter int W = 16
) (
  input  logic [W-1:0] res,
  input  logic         c_into_top,
  input  logic         c_out_top,
  output logic         ovf,
  output logic         is_zero
);
  always_comb begin
    ovf     = c_into_top ^ c_out_top;
    is_zero = ~|res;
  end
endmodule

// File: rtl/alu_bitslice.sv
module alu_bitslice
  import alu_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [W-1:0] opnd_a,
  input  logic [W-1:0] opnd_b,
  input  logic         inv_a,
  input  logic         inv_b,
  input  logic         carry_in,
  input  logic [1:0]   op_sel,
  output logic [W-1:0] result,
  output logic         overflow,
  output logic         zero
);
  localparam int MSB = W - 1;

  alu_op_e     op;
  logic [W:0]  carry;
  logic [MSB:0] raw_sum;
  logic [MSB:0] less_in;

  assign op       = alu_op_e'(op_sel);
  assign carry[0] = carry_in;
  assign less_in  = {{(W-1){1'b0}}, raw_sum[MSB]};

  for (genvar i = 0; i < W; i++) begin : g_slice
    alu_slice u_slice (
      .a       (opnd_a[i]),
      .b       (opnd_b[i]),
      .inv_a   (inv_a),
      .inv_b   (inv_b),
      .cin     (carry[i]),
      .less    (less_in[i]),
      .op      (op),
      .y       (result[i]),
      .cout    (carry[i+1]),
      .sum_raw (raw_sum[i])
    );
  end

  alu_flags #(.W(W)) u_flags (
    .res        (result),
    .c_into_top (carry[MSB]),
    .c_out_top  (carry[W]),
    .ovf        (overflow),
    .is_zero    (zero)
  );

  // Cross-slice checks against arithmetic on the ports
  logic [W:0]   plain_sum;
  logic [MSB:0] plain_diff;
  always_comb begin
    plain_sum  = {1'b0, opnd_a} + {1'b0, opnd_b} + {{W{1'b0}}, carry_in};
    plain_diff = opnd_a - opnd_b;
    if (op_sel == 2'b10 && !inv_a && !inv_b)
      assert_ripple_sum_R3: assert ({carry[W], result} == plain_sum);
    if (op_sel == 2'b10 && !inv_a && inv_b && carry_in)
      assert_subtract_R4: assert (result == plain_diff);
    if (op_sel == 2'b11 && !inv_a && inv_b && carry_in)
      assert_compare_bit_R5: assert (result == {{(W-1){1'b0}}, plain_diff[MSB]});
    if (op_sel == 2'b10 && !inv_a && !inv_b)
      assert_signed_ovf_R6: assert (overflow ==
        ((opnd_a[MSB] == opnd_b[MSB]) && (result[MSB] != opnd_a[MSB])));
  end
endmodule

// File: tb/tb_alu_bitslice.sv
module tb_alu_bitslice;
  localparam int W = 16;
  localparam int CLK_PERIOD = 10;

  logic clk;
  logic rst_n;
  logic [W-1:0] a, b;
  logic na, nb, ci;
  logic [1:0] op;
  logic [W-1:0] res;
  logic ovf, zf;
  int checks, fails;
  bit done;

  alu_bitslice #(.W(W)) dut (
    .opnd_a(a), .opnd_b(b), .inv_a(na), .inv_b(nb), .carry_in(ci),
    .op_sel(op), .result(res), .overflow(ovf), .zero(zf)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [W+1:0] model(input logic [W-1:0] xa, input logic [W-1:0] xb,
                                         input logic ia, input logic ib, input logic c,
                                         input logic [1:0] o);
    logic [W-1:0] ea, eb, r;
    logic [W:0] s;
    logic v;
    ea = ia ? ~xa : xa;
    eb = ib ? ~xb : xb;
    s  = {1'b0, ea} + {1'b0, eb} + {{W{1'b0}}, c};
    v  = (ea[W-1] == eb[W-1]) && (s[W-1] != ea[W-1]);
    case (o)
      2'b00: r = ea & eb;
      2'b01: r = ea | eb;
      2'b10: r = s[W-1:0];
      default: r = {{(W-1){1'b0}}, s[W-1]};
    endcase
    return {v, (r == '0), r};
  endfunction

  task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%h expected=%h (a=%h b=%h na=%b nb=%b cin=%b op=%b)",
               tag, act, exp, a, b, na, nb, ci, op);
    end
  endtask

  task automatic run(input logic [W-1:0] xa, input logic [W-1:0] xb, input logic ia,
                     input logic ib, input logic c, input logic [1:0] o);
    logic [W+1:0] e;
    a = xa; b = xb; na = ia; nb = ib; ci = c; op = o;
    @(negedge clk);
    e = model(xa, xb, ia, ib, c, o);
    case (o)
      2'b00: check("R1 and", res, e[W-1:0]);
      2'b01: check("R2 or", res, e[W-1:0]);
      2'b10: begin
        if (!ia && ib && c) check("R4 sub", res, xa - xb);
        else check("R3 sum", res, e[W-1:0]);
        check("R6 overflow", {{(W-1){1'b0}}, ovf}, {{(W-1){1'b0}}, e[W+1]});
      end
      default: check("R5 compare", res, e[W-1:0]);
    endcase
    check("R7 zero", {{(W-1){1'b0}}, zf}, {{(W-1){1'b0}}, e[W]});
  endtask

  initial begin
    checks = 0; fails = 0; done = 1'b0;
    a = '0; b = '0; na = 0; nb = 0; ci = 0; op = 2'b00;
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    // idle state: all-zero inputs give zero result and flag (R7)
    check("R7 idle result", res, '0);
    check("R7 idle zero", {{(W-1){1'b0}}, zf}, {{(W-1){1'b0}}, 1'b1});
    // directed corners
    run(16'h7FFF, 16'h0001, 0, 0, 0, 2'b10);   // R6 positive overflow
    run(16'h8000, 16'h0001, 0, 1, 1, 2'b10);   // R4/R6 negative overflow
    run(16'h8000, 16'h8000, 0, 0, 0, 2'b10);   // R6 and R7 together
    run(16'h1234, 16'h1234, 0, 1, 1, 2'b10);   // R4 equal -> zero
    run(16'h1234, 16'h1234, 0, 1, 1, 2'b11);   // R5 equal -> 0
    run(16'hFFFF, 16'h0001, 0, 1, 1, 2'b11);   // R5 -1 < 1
    run(16'h0001, 16'hFFFF, 0, 1, 1, 2'b11);   // R5 1 > -1
    run(16'h8000, 16'h0001, 0, 1, 1, 2'b11);   // R5 raw sign ignores overflow
    run(16'h0000, 16'h0000, 0, 0, 0, 2'b00);   // R1/R7
    run(16'h0000, 16'h0000, 0, 0, 0, 2'b01);   // R2/R7
    run(16'hF0F0, 16'h0FF0, 1, 0, 0, 2'b00);   // R1 inverted a
    run(16'hF0F0, 16'h0FF0, 0, 1, 0, 2'b01);   // R2 inverted b
    begin
      int seed;
      logic [W-1:0] ra, rb;
      logic [3:0] ctl;
      logic [1:0] ro;
      seed = 32'h5EED;
      ra = W'($urandom(seed));
      for (int k = 0; k < 4000; k++) begin
        ra  = W'($urandom());
        rb  = W'($urandom());
        ctl = 4'($urandom());
        ro  = 2'($urandom());
        if (ctl[3]) rb = ra;
        run(ra, rb, ctl[0], ctl[1], ctl[2], ro);
      end
    end
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule